// File: doc/BRIEF.md
# Interval-Driven Source Throttle Controller

This block is a feedback controller placed next to the request sources of a shared memory system. It gives each core a cap on outstanding requests and an injection rate. At the end of every fixed-length interval it samples the slowdown estimate for each application, the software-set weight of each application and a matrix of interference counts. From these it decides whether the system has become too unfair.

Each slowdown is first scaled by its weight. The application with the largest scaled slowdown is the victim. Among the remaining applications, the one that caused the victim the most interference is the culprit. Unfairness is the ratio of the largest to the smallest scaled slowdown. When this ratio is above a software-programmed target, the culprit is throttled down one level and the victim is throttled up one level. Otherwise every level stays where it is.

Levels are 3-bit indices that saturate at both ends. The estimates collected during one interval determine the limits that apply during the next one. How the estimates are produced is outside this block.

Top module: `stc_throttle_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first decision, every core is at level RESET_LVL (2 by default): max_outst reads 4 and inj_rate reads 3.
- R2: A core at level L (0..MAX_LVL, MAX_LVL=4) drives max_outst = 2^L, giving 1, 2, 4, 8 or 16, and inj_rate = L+1.
- R3: A decision is taken only on the clock edge where the interval counter completes INTERVAL cycles. The first such edge is the INTERVAL-th edge after reset is released. Inputs are sampled on that edge and the outputs are unchanged on every other edge.
- R4: The scaled slowdown of core i is (slowdown_i × weight_i) >> 4. The weight is unsigned with 4 fractional bits, so 16 means 1.0.
- R5: Slowdowns and the target carry 8 fractional bits. Throttling happens only when max×256 > target×min, computed on the scaled slowdowns. At equality, or when all values are zero, no level changes.
- R6: The victim is the core with the largest scaled slowdown. A tie goes to the lowest core index.
- R7: The culprit is the core c ≠ victim with the largest count interf[victim][c], a tie going to the lowest index. The count for victim v and source c sits at bits [(v*N_CORES+c)*IF_W +: IF_W].
- R8: On throttling, the culprit's level drops by one and saturates at 0. The victim's level rises by one and saturates at MAX_LVL. All other levels are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slowdown_i | input | N_CORES*SD_W | Per-core slowdown estimate, 8 fractional bits |
| weight_i | input | N_CORES*WT_W | Per-core priority weight, 4 fractional bits |
| interf_i | input | N_CORES*N_CORES*IF_W | Interference counts, indexed by victim and then source |
| target_i | input | SD_W | Unfairness target, 8 fractional bits |
| max_outst_o | output | N_CORES*(MAX_LVL+1) | Per-core cap on outstanding requests |
| inj_rate_o | output | N_CORES*3 | Per-core injection rate (level + 1) |

## Verification
Throttling down the culprit and throttling up the victim happen on the same decision edge, to two different cores. Either update can saturate while the other still moves.

The bench provokes this by presenting the same victim and culprit for several intervals in a row. One core then pins at level 4 while another pins at level 0. Each core's outputs are compared after every decision against a bench model of the step-and-saturate rule.

Random intervals, with ties among both slowdowns and interference counts, also check that the victim and culprit selections never interfere with each other.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/stc_interval_timer.sv
module stc_interval_timer #(
  parameter int INTERVAL = 256
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/stc_weigh.sv
module stc_weigh #(
  parameter int N_CORES = 4,
  parameter int SD_W    = 16,
  parameter int WT_W    = 8,
  parameter int WT_FRAC = 4,
  localparam int WS_W   = SD_W + WT_W - WT_FRAC
) (
  input  logic [N_CORES*SD_W-1:0] slowdown,
  input  logic [N_CORES*WT_W-1:0] weight,
  output logic [N_CORES*WS_W-1:0] scaled
);
  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    logic [SD_W+WT_W-1:0] prod;
    assign prod = (SD_W+WT_W)'(slowdown[g*SD_W +: SD_W]) * (SD_W+WT_W)'(weight[g*WT_W +: WT_W]);
    assign scaled[g*WS_W +: WS_W] = prod[SD_W+WT_W-1:WT_FRAC];
  end
endmodule

// File: rtl/stc_select.sv
module stc_select #(
  parameter int N_CORES = 4,
  parameter int WS_W    = 20,
  parameter int SD_W    = 16,
  parameter int IF_W    = 12,
  parameter int FRAC    = 8,
  localparam int IDX_W  = $clog2(N_CORES)
) (
  input  logic [N_CORES*WS_W-1:0]         scaled,
  input  logic [N_CORES*N_CORES*IF_W-1:0] interf,
  input  logic [SD_W-1:0]                 target,
  output logic [IDX_W-1:0]                victim,
  output logic [IDX_W-1:0]                culprit,
  output logic                            exceed
);
  localparam int CW = WS_W + SD_W + FRAC;

  logic [WS_W-1:0] vmax, vmin;
  logic [IF_W-1:0] cbest, cval;
  logic            found;
  logic [CW-1:0]   lhs, rhs;

  always_comb begin
    victim = '0;
    vmax   = scaled[0 +: WS_W];
    vmin   = scaled[0 +: WS_W];
    for (int i = 1; i < N_CORES; i++) begin
      if (scaled[i*WS_W +: WS_W] > vmax) begin
        vmax   = scaled[i*WS_W +: WS_W];
        victim = IDX_W'(i);
      end
      if (scaled[i*WS_W +: WS_W] < vmin) vmin = scaled[i*WS_W +: WS_W];
    end
  end

  always_comb begin
    culprit = '0;
    cbest   = '0;
    found   = 1'b0;
    for (int c = 0; c < N_CORES; c++) begin
      cval = interf[(int'(victim)*N_CORES + c)*IF_W +: IF_W];
      if (IDX_W'(c) != victim && (!found || cval > cbest)) begin
        cbest   = cval;
        culprit = IDX_W'(c);
        found   = 1'b1;
      end
    end
  end

  assign lhs    = CW'(vmax) << FRAC;
  assign rhs    = CW'(target) * CW'(vmin);
  assign exceed = lhs > rhs;
endmodule

// File: rtl/stc_throttle_ctrl.sv
module stc_throttle_ctrl #(
  parameter int N_CORES   = 4,
  parameter int SD_W      = 16,
  parameter int WT_W      = 8,
  parameter int WT_FRAC   = 4,
  parameter int IF_W      = 12,
  parameter int INTERVAL  = 256,
  parameter int MAX_LVL   = 4,
  parameter int RESET_LVL = 2,
  localparam int MO_W     = MAX_LVL + 1,
  localparam int LVL_W    = stc_pkg::LVL_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_CORES*SD_W-1:0]         slowdown_i,
  input  logic [N_CORES*WT_W-1:0]         weight_i,
  input  logic [N_CORES*N_CORES*IF_W-1:0] interf_i,
  input  logic [SD_W-1:0]                 target_i,
  output logic [N_CORES*MO_W-1:0]         max_outst_o,
  output logic [N_CORES*LVL_W-1:0]        inj_rate_o
);
  import stc_pkg::*;
  localparam int WS_W  = SD_W + WT_W - WT_FRAC;
  localparam int IDX_W = $clog2(N_CORES);
  localparam int FRAC  = 8;

  logic                    tick;
  logic [N_CORES*WS_W-1:0] scaled;
  logic [IDX_W-1:0]        victim, culprit;
  logic                    exceed;

  stc_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst(rst), .tick(tick)
  );

  stc_weigh #(.N_CORES(N_CORES), .SD_W(SD_W), .WT_W(WT_W), .WT_FRAC(WT_FRAC)) u_weigh (
    .slowdown(slowdown_i), .weight(weight_i), .scaled(scaled)
  );

  stc_select #(.N_CORES(N_CORES), .WS_W(WS_W), .SD_W(SD_W), .IF_W(IF_W), .FRAC(FRAC)) u_sel (
    .scaled(scaled), .interf(interf_i), .target(target_i),
    .victim(victim), .culprit(culprit), .exceed(exceed)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_lvl
    lvl_t lvl_q, lvl_d;

    always_comb begin
      lvl_d = lvl_q;
      if (tick && exceed) begin
        if (culprit == IDX_W'(g) && lvl_q != '0)
          lvl_d = lvl_q - 1'b1;
        else if (victim == IDX_W'(g) && lvl_q != LVL_W'(MAX_LVL))
          lvl_d = lvl_q + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q                        <= LVL_W'(RESET_LVL);
        max_outst_o[g*MO_W +: MO_W]  <= MO_W'(1) << RESET_LVL;
        inj_rate_o[g*LVL_W +: LVL_W] <= LVL_W'(RESET_LVL + 1);
      end else begin
        lvl_q                        <= lvl_d;
        max_outst_o[g*MO_W +: MO_W]  <= MO_W'(1) << lvl_d;
        inj_rate_o[g*LVL_W +: LVL_W] <= lvl_d + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int N_CORES   = 4,
  parameter int MO_W      = 5,
  parameter int LVL_W     = 3,
  parameter int RESET_LVL = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     exceed,
  input logic [N_CORES*MO_W-1:0]  max_outst,
  input logic [N_CORES*LVL_W-1:0] inj_rate
);
  // R3: no output movement away from the interval boundary
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(max_outst) && $stable(inj_rate)));

  // R5: a boundary without excess unfairness leaves all limits alone
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (tick && !exceed) |=> $stable(max_outst));

  for (genvar g = 0; g < N_CORES; g++) begin : g_chk
    // R1: values seen right after reset release
    a_r1_reset_lvl: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (inj_rate[g*LVL_W +: LVL_W] == LVL_W'(RESET_LVL + 1)));

    // R2: cap and rate describe the same level
    a_r2_pair: assert property (@(posedge clk) disable iff (rst)
      ($onehot(max_outst[g*MO_W +: MO_W]) &&
       max_outst[g*MO_W +: MO_W] == (MO_W'(1) << (inj_rate[g*LVL_W +: LVL_W] - 1'b1))));

    // R8: a level moves by at most one step per decision
    a_r8_one_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (inj_rate[g*LVL_W +: LVL_W] == $past(inj_rate[g*LVL_W +: LVL_W]) ||
                inj_rate[g*LVL_W +: LVL_W] == $past(inj_rate[g*LVL_W +: LVL_W]) + 1'b1 ||
                inj_rate[g*LVL_W +: LVL_W] + 1'b1 == $past(inj_rate[g*LVL_W +: LVL_W])));
  end
endmodule

bind stc_throttle_ctrl stc_checker #(
  .N_CORES(N_CORES), .MO_W(MO_W), .LVL_W(LVL_W), .RESET_LVL(RESET_LVL)
) i_chk (
  .clk(clk), .rst(rst), .tick(tick), .exceed(exceed),
  .max_outst(max_outst_o), .inj_rate(inj_rate_o)
);

// File: tb/test_stc_throttle_ctrl.sv
module test_stc_throttle_ctrl;
  localparam int N   = 4;
  localparam int SDW = 16;
  localparam int WTW = 8;
  localparam int IFW = 12;
  localparam int INT = 16;
  localparam int MXL = 4;
  localparam int RSL = 2;
  localparam int MOW = MXL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*SDW-1:0]   slowdown_i = '0;
  logic [N*WTW-1:0]   weight_i   = '0;
  logic [N*N*IFW-1:0] interf_i   = '0;
  logic [SDW-1:0]     target_i   = '0;
  logic [N*MOW-1:0]   max_outst_o;
  logic [N*3-1:0]     inj_rate_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int sd[N];
  int wt[N];
  int itf[N][N];
  int tgt;
  int lvl[N];

  always #10 clk = ~clk;

  stc_throttle_ctrl #(.N_CORES(N), .SD_W(SDW), .WT_W(WTW), .WT_FRAC(4), .IF_W(IFW),
                      .INTERVAL(INT), .MAX_LVL(MXL), .RESET_LVL(RSL)) i_stc_throttle_ctrl (
    .clk(clk), .rst(rst), .slowdown_i(slowdown_i), .weight_i(weight_i),
    .interf_i(interf_i), .target_i(target_i),
    .max_outst_o(max_outst_o), .inj_rate_o(inj_rate_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < N; i++) begin
      check(tag, $sformatf("core%0d max_outst", i), int'(max_outst_o[i*MOW +: MOW]), 1 << lvl[i]);
      check(tag, $sformatf("core%0d inj_rate", i), int'(inj_rate_o[i*3 +: 3]), lvl[i] + 1);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      slowdown_i[i*SDW +: SDW] = SDW'(sd[i]);
      weight_i[i*WTW +: WTW]   = WTW'(wt[i]);
      for (int c = 0; c < N; c++) interf_i[(i*N+c)*IFW +: IFW] = IFW'(itf[i][c]);
    end
    target_i = SDW'(tgt);
  endtask

  // Bench model of R4..R8
  task automatic model();
    longint ws[N];
    longint mx, mn;
    int vic, cul, best;
    for (int i = 0; i < N; i++) ws[i] = (longint'(sd[i]) * longint'(wt[i])) >> 4;
    vic = 0; mx = ws[0]; mn = ws[0];
    for (int i = 1; i < N; i++) begin
      if (ws[i] > mx) begin mx = ws[i]; vic = i; end
      if (ws[i] < mn) mn = ws[i];
    end
    cul = -1; best = -1;
    for (int c = 0; c < N; c++)
      if (c != vic && itf[vic][c] > best) begin best = itf[vic][c]; cul = c; end
    if (mx * 256 > longint'(tgt) * mn) begin
      if (lvl[cul] > 0)   lvl[cul]--;
      if (lvl[vic] < MXL) lvl[vic]++;
    end
  endtask

  task automatic run_interval(string tag);
    drive();
    repeat (INT/2) @(posedge clk);
    @(negedge clk);
    check_all("R3");
    model();
    repeat (INT - INT/2) @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic set_all(int s, int w);
    for (int i = 0; i < N; i++) begin
      sd[i] = s; wt[i] = w;
      for (int c = 0; c < N; c++) itf[i][c] = 0;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) lvl[i] = RSL;
    set_all(256, 16); tgt = 256; drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst = 1'b0;
    check_all("R1");

    // R5: equal slowdowns give a ratio of exactly 1.0, no change
    run_interval("R5");
    // R5: ratio exactly at target (512/256 = 2.0), no change
    set_all(256, 16); sd[0] = 512; tgt = 512;
    run_interval("R5");
    // R5: just above target
    sd[0] = 513; itf[0][1] = 3;
    run_interval("R5");
    // R7: culprit tie between cores 2 and 3 goes to core 2
    set_all(256, 16); sd[0] = 512; tgt = 256;
    itf[0][1] = 5; itf[0][2] = 9; itf[0][3] = 9;
    run_interval("R7");
    // R6: victim tie between cores 1 and 2 goes to core 1; culprit tie to core 0
    set_all(300, 16); sd[1] = 600; sd[2] = 600; sd[3] = 200;
    itf[1][0] = 7; itf[1][2] = 7; itf[1][3] = 1;
    run_interval("R6");
    // R4: weight 3.0 makes core 2 the victim despite equal raw slowdowns
    set_all(400, 16); wt[2] = 48; tgt = 512;
    itf[2][0] = 1; itf[2][1] = 2; itf[2][3] = 3;
    run_interval("R4");
    // R8: repeated victim 0 / culprit 1 until both saturate
    set_all(100, 16); sd[0] = 2000; tgt = 256; itf[0][1] = 50; itf[0][2] = 1; itf[0][3] = 1;
    for (int k = 0; k < 5; k++) run_interval("R8");
    // R5: all-zero slowdowns never throttle
    set_all(0, 16); tgt = 0;
    run_interval("R5");
    // R5: zero minimum with a nonzero maximum throttles
    sd[3] = 10; itf[3][0] = 4;
    run_interval("R5");

    // Random intervals, R8 with R4/R6/R7 exercised together
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < N; i++) begin
        sd[i] = int'($urandom_range(1, 2047));
        if ($urandom_range(0, 3) == 0) sd[i] = sd[0];
        wt[i] = int'($urandom_range(4, 40));
        for (int c = 0; c < N; c++) itf[i][c] = int'($urandom_range(0, 15)) * 256;
      end
      tgt = int'($urandom_range(256, 1536));
      run_interval("R8");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule